// File: doc/BRIEF.md
# Single-Wire Bus Time-Slot Engine

This block drives one open-drain single-wire bus line and produces the low-level time slots such a bus needs. Firmware or a higher-level sequencer gives it one command at a time: a bus reset with presence detection, a write slot carrying a 0 or a 1, a read slot, or a combined "touch" slot. The block pulls the line low through an output-enable for the required time, then releases it to the external pull-up. Where the command needs it, the block samples the line at a fixed point after release and returns one result bit with a single-cycle done pulse.

All slot durations are in microseconds. A prescaler derives a microsecond tick from the system clock, and the parameter `CLKS_PER_US` sets its ratio. A run-time multiplier stretches every duration by an integer factor, so that slow or long buses can be served without a rebuild. The incoming line level passes through a two-flop synchroniser before it is sampled. Byte framing, addressing commands, checksums and strong pull-up control are left to the logic above this block.

Top module: `owire_slot_gen`

## Requirements
- R1: After reset the block is idle: `cmd_ready_o`=1, `busy_o`=0, `done_o`=0 and `line_oe_o`=0 (line released).
- R2: A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `busy_o` is 1 from the next cycle until the slot ends, and `cmd_ready_o` is 0 for that whole time. Commands presented while busy are ignored. `cmd_kind_i` encoding: 2'b00 bus reset, 2'b01 write (`cmd_bit_i` gives the value), 2'b10 read, 2'b11 touch.
- R3: A write slot with `cmd_bit_i`=1 holds the line low for 6 us, then keeps it released for 64 us (70 us busy in total). The result is 0.
- R4: A write slot with `cmd_bit_i`=0 holds the line low for 60 us, then keeps it released for 10 us (70 us busy). The result is 0.
- R5: A read slot holds the line low for 6 us and samples the synchronised line 9 us after release. It then recovers for 55 us (70 us busy). The result is the sampled level (1 = line high).
- R6: A bus reset holds the line low for 500 us and samples the line 70 us after release. It then stays idle for 430 more us (1000 us busy). The result is 0 when a device pulled the line low (present) and 1 when none did.
- R7: A touch command with `cmd_bit_i`=1 behaves exactly as a read slot. With `cmd_bit_i`=0 it behaves as a write-0 slot and returns 0.
- R8: Every duration is multiplied by `mult_i`, which is sampled when the command is accepted. A value of 0 acts as 1. Each microsecond lasts `CLKS_PER_US` clock cycles.
- R9: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls. `result_o` changes only with `done_o` and holds its value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_kind_i | input | 2 | Command kind (see R2) |
| cmd_bit_i | input | 1 | Data bit for write and touch |
| mult_i | input | MULT_W | Duration multiplier, 0 treated as 1 |
| busy_o | output | 1 | Slot in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | Sampled bit or presence flag (0 = present) |
| line_oe_o | output | 1 | 1 pulls the bus line low |
| line_i | input | 1 | Bus line level, asynchronous |

## Verification
The bound checker watches the handshake and framing on every cycle. It checks that an accepted command starts a low pulse at once, that the line is pulled only while busy, that done is a lone pulse that follows busy, and that the result moves only with done. The exact low and busy durations, the position of the sample point and the values returned can only be seen in the bench. The bench measures cycle counts per command against a slave model that pulls the line for presence and read-0 responses. It does this over directed corner cases (zero multiplier, absent device, commands while busy) and random command mixes.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [1:0] {
        KIND_RESET = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_READ  = 2'b10,
        KIND_TOUCH = 2'b11
    } cmd_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_WAIT = 2'b10,
        PH_TAIL = 2'b11
    } phase_e;

    // Slot shape in microseconds: low time, released time up to the
    // sample point, and recovery after the sample point.
    typedef struct packed {
        logic [9:0] low_us;
        logic [9:0] wait_us;
        logic [9:0] tail_us;
        logic       use_sample;
    } slot_shape_t;

    function automatic slot_shape_t shape_of(input cmd_kind_e kind, input logic bit_val);
        slot_shape_t s;
        logic        as_read;
        as_read = (kind == KIND_READ) || ((kind == KIND_TOUCH) && bit_val);
        if (kind == KIND_RESET) begin
            s = '{low_us: 10'd500, wait_us: 10'd70, tail_us: 10'd430, use_sample: 1'b1};
        end else if (as_read) begin
            s = '{low_us: 10'd6, wait_us: 10'd9, tail_us: 10'd55, use_sample: 1'b1};
        end else if ((kind == KIND_WRITE) && bit_val) begin
            s = '{low_us: 10'd6, wait_us: 10'd64, tail_us: 10'd0, use_sample: 1'b0};
        end else begin
            s = '{low_us: 10'd60, wait_us: 10'd10, tail_us: 10'd0, use_sample: 1'b0};
        end
        return s;
    endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b1;
            stable_q <= 1'b1;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
    parameter int CLKS_PER_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i || (cnt_q == LAST)) cnt_d = '0;
        else                              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/owire_slot_gen.sv
module owire_slot_gen
    import owire_pkg::*;
#(
    parameter int CLKS_PER_US = 4,
    parameter int MULT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_kind_i,
    input  logic              cmd_bit_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              result_o,
    output logic              line_oe_o,
    input  logic              line_i
);
    localparam int MULT_MAX = (1 << MULT_W) - 1;
    localparam int US_W     = $clog2(1000 * MULT_MAX + 1);

    typedef struct packed {
        phase_e          phase;
        logic [US_W-1:0] remain;
        logic [US_W-1:0] wait_len;
        logic [US_W-1:0] tail_len;
        logic            use_sample;
        logic            sample;
        logic            oe;
        logic            done;
        logic            result;
    } state_t;

    state_t          st_d, st_q;
    logic            line_sync;
    logic            us_tick;
    logic            accept;
    logic            last_us;
    slot_shape_t     shape;
    logic [US_W-1:0] mult_eff;

    owire_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_sync)
    );

    owire_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .tick_o    (us_tick)
    );

    assign accept   = cmd_valid_i && (st_q.phase == PH_IDLE);
    assign last_us  = us_tick && (st_q.remain == US_W'(1));
    assign shape    = shape_of(cmd_kind_e'(cmd_kind_i), cmd_bit_i);
    assign mult_eff = (mult_i == '0) ? US_W'(1) : US_W'(mult_i);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.phase      = PH_LOW;
                    st_d.oe         = 1'b1;
                    st_d.remain     = US_W'(shape.low_us) * mult_eff;
                    st_d.wait_len   = US_W'(shape.wait_us) * mult_eff;
                    st_d.tail_len   = US_W'(shape.tail_us) * mult_eff;
                    st_d.use_sample = shape.use_sample;
                    st_d.sample     = 1'b0;
                end
            end
            PH_LOW: begin
                if (last_us) begin
                    st_d.phase  = PH_WAIT;
                    st_d.oe     = 1'b0;
                    st_d.remain = st_q.wait_len;
                end else if (us_tick) begin
                    st_d.remain = st_q.remain - US_W'(1);
                end
            end
            PH_WAIT: begin
                if (last_us) begin
                    st_d.sample = st_q.use_sample ? line_sync : 1'b0;
                    if (st_q.tail_len == '0) begin
                        st_d.phase  = PH_IDLE;
                        st_d.done   = 1'b1;
                        st_d.result = st_q.use_sample ? line_sync : 1'b0;
                    end else begin
                        st_d.phase  = PH_TAIL;
                        st_d.remain = st_q.tail_len;
                    end
                end else if (us_tick) begin
                    st_d.remain = st_q.remain - US_W'(1);
                end
            end
            PH_TAIL: begin
                if (last_us) begin
                    st_d.phase  = PH_IDLE;
                    st_d.done   = 1'b1;
                    st_d.result = st_q.sample;
                end else if (us_tick) begin
                    st_d.remain = st_q.remain - US_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, remain: '0, wait_len: '0, tail_len: '0,
                      use_sample: 1'b0, sample: 1'b0, oe: 1'b0, done: 1'b0,
                      result: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready_o = (st_q.phase == PH_IDLE);
    assign busy_o      = (st_q.phase != PH_IDLE);
    assign done_o      = st_q.done;
    assign result_o    = st_q.result;
    assign line_oe_o   = st_q.oe;
endmodule

// File: rtl/owire_slot_gen_chk.sv
module owire_slot_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid_i,
    input logic cmd_ready_o,
    input logic busy_o,
    input logic done_o,
    input logic result_o,
    input logic line_oe_o
);
    // R2: an accepted command starts busy with the line pulled low
    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o) |=> (busy_o && line_oe_o));

    // R2: the line is never pulled while the block is idle
    assert_oe_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe_o |-> busy_o);

    // R9: done appears right after a busy period ends
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9: done is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: the result only moves together with done
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    // R2: release of the line happens only inside a slot
    assert_release_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe_o) |-> busy_o);
endmodule

bind owire_slot_gen owire_slot_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o),
    .line_oe_o   (line_oe_o)
);

// File: tb/owire_slot_gen_tb.sv
module owire_slot_gen_tb;
    localparam int CPU = 4;
    localparam int MW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_kind = 2'b00;
    logic          cmd_bit = 1'b0;
    logic [MW-1:0] mult = '0;
    logic          busy, done, result, line_oe, line;
    logic          slave_pull = 1'b0;
    int            slave_mode = 0;
    int            slave_m = 1;
    int            errors = 0;
    int            checks = 0;

    always #5 clk = ~clk;

    assign line = !(line_oe || slave_pull);

    owire_slot_gen #(.CLKS_PER_US(CPU), .MULT_W(MW)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid_i (cmd_valid), .cmd_ready_o (cmd_ready),
        .cmd_kind_i (cmd_kind), .cmd_bit_i (cmd_bit), .mult_i (mult),
        .busy_o (busy), .done_o (done), .result_o (result),
        .line_oe_o (line_oe), .line_i (line)
    );

    // Slave model: mode 1 answers a reset with presence, mode 2 answers a read with 0.
    initial begin
        forever begin
            @(negedge line_oe);
            if (slave_mode == 1) begin
                repeat (4) @(posedge clk);
                slave_pull = 1'b1;
                repeat (70 * slave_m * CPU + 16) @(posedge clk);
                slave_pull = 1'b0;
            end else if (slave_mode == 2) begin
                repeat (2) @(posedge clk);
                slave_pull = 1'b1;
                repeat (9 * slave_m * CPU + 8) @(posedge clk);
                slave_pull = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_read(input logic [1:0] k, input logic b);
        return (k == 2'b10) || (k == 2'b11 && b);
    endfunction

    function automatic int exp_low(input logic [1:0] k, input logic b);
        if (k == 2'b00) return 500;
        if (is_read(k, b)) return 6;
        if (k == 2'b01 && b) return 6;
        return 60;
    endfunction

    function automatic int exp_total(input logic [1:0] k);
        return (k == 2'b00) ? 1000 : 70;
    endfunction

    function automatic int exp_res(input logic [1:0] k, input logic b, input int mode);
        if (k == 2'b00) return (mode == 1) ? 0 : 1;
        if (is_read(k, b)) return (mode == 2) ? 0 : 1;
        return 0;
    endfunction

    function automatic string req_of(input logic [1:0] k, input logic b);
        if (k == 2'b00) return "R6";
        if (k == 2'b11) return "R7";
        if (k == 2'b10) return "R5";
        return b ? "R3" : "R4";
    endfunction

    task automatic run(input logic [1:0] k, input logic b, input int m,
                       input int mode, input bit junk);
        int me;
        int oe_c;
        int busy_c;
        int cyc;
        int extra;
        string rq;
        me = (m == 0) ? 1 : m;
        oe_c = 0; busy_c = 0; cyc = 1; extra = 0;
        rq = req_of(k, b);
        slave_mode = mode;
        slave_m = me;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_bit = b; mult = MW'(m);
        @(negedge clk);
        if (junk) begin
            cmd_kind = ~k; cmd_bit = ~b; mult = MW'(7);
        end else begin
            cmd_valid = 1'b0;
        end
        while (!done && cyc < 40000) begin
            oe_c += int'(line_oe);
            busy_c += int'(busy);
            if (junk && cyc == 5) chk("R2 ready low while busy", int'(cmd_ready), 0);
            if (junk && cyc == 10) cmd_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk({rq, " done seen"}, int'(done), 1);
        chk({rq, " R8 low cycles"}, oe_c, exp_low(k, b) * me * CPU);
        chk({rq, " R8 busy cycles"}, busy_c, exp_total(k) * me * CPU);
        chk({rq, " result"}, int'(result), exp_res(k, b, mode));
        chk("R9 busy low at done", int'(busy), 0);
        if (junk) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                extra += int'(busy) + int'(done) + int'(line_oe);
                if (i == 3) chk("R9 result held", int'(result), exp_res(k, b, mode));
            end
            chk("R2 command during busy ignored", extra, 0);
        end
        slave_mode = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 oe", int'(line_oe), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready after release", int'(cmd_ready), 1);

        run(2'b01, 1'b1, 1, 0, 1'b0);  // R3
        run(2'b01, 1'b0, 1, 0, 1'b0);  // R4
        run(2'b10, 1'b0, 1, 0, 1'b0);  // R5 line high
        run(2'b10, 1'b0, 1, 2, 1'b0);  // R5 device answers 0
        run(2'b00, 1'b0, 1, 1, 1'b0);  // R6 present
        run(2'b00, 1'b0, 1, 0, 1'b0);  // R6 absent
        run(2'b11, 1'b1, 1, 2, 1'b0);  // R7 touch read
        run(2'b11, 1'b0, 1, 0, 1'b0);  // R7 touch write-0
        run(2'b01, 1'b0, 0, 0, 1'b0);  // R8 multiplier zero
        run(2'b01, 1'b0, 3, 0, 1'b0);  // R8 multiplier 3
        run(2'b00, 1'b0, 2, 1, 1'b0);  // R8 stretched reset
        run(2'b10, 1'b0, 1, 2, 1'b1);  // R2 R9 junk while busy

        for (int n = 0; n < 20; n++) begin
            logic [1:0] k;
            logic       b;
            int         m;
            int         mode;
            k = 2'($urandom_range(0, 3));
            b = 1'($urandom_range(0, 1));
            m = $urandom_range(0, 3);
            mode = 0;
            if (k == 2'b00) mode = $urandom_range(0, 1);
            else if (is_read(k, b)) mode = 2 * $urandom_range(0, 1);
            run(k, b, m, mode, ($urandom_range(0, 3) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule